// File: doc/BRIEF.md
# Token-Passing Serial Sample Output Port

This block collects filtered 24-bit samples from four conversion channels and joins each one with an 8-bit status byte. The resulting 32-bit words wait in a small first-in first-out queue until a downstream telemetry controller asks for them. The controller asks by raising a token line. If the queue holds a word, the port shifts that word out, MSB first, on a serial clock that the controller supplies. It then hands the token on to the next device in the daisy chain. If the queue is empty, the token goes straight through. An active-low ready line tells the controller that words are waiting.

The status byte carries four things: a sticky per-channel modulator flag, the channel number, a time-break marker and a queue-overflow marker. The time-break marker comes from a programmable countdown that a rising edge on the time-break input starts. When the countdown runs out, the next word of every channel carries the marker exactly once.

The serial clock and the token input are asynchronous to the system clock. The port synchronizes them and detects their edges in the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `sample_token_port`

## Requirements
- R1: Each word is laid out as: bit 31 modulator flag, bits 30:29 channel number (zero based, 0 = first channel, 3 = fourth), bit 28 time-break marker, bit 27 overflow marker, bits 26:24 zero, bits 23:0 the sample. The word is sent MSB first.
- R2: The queue holds up to 8 words and sends them in the order they arrived.
- R3: `rdy_n` is 0 while the queue holds at least one word, and 1 when it is empty.
- R4: A rising token with a non-empty queue sends exactly one 32-bit word. After the 32nd falling edge of the serial clock, `tok_out` is 1 for one serial-clock period and returns to 0 at the next falling edge.
- R5: A rising token with an empty queue is copied to `tok_out` until the token falls. No data is sent.
- R6: `ser_dat` changes only after a falling edge of `ser_clk` and stays stable while `ser_clk` is high.
- R7: A pulse on `mod_flag[c]` sets bit 31 in the next word queued for channel c only. Later words of that channel carry 0 in that bit.
- R8: A rising edge on `tbrk_in` starts a countdown of `tb_delay` system clocks. When it expires, bit 28 is set in exactly one subsequent word of each channel. Words queued before expiry carry 0 in that bit.
- R9: A sample offered while the queue is full is dropped. The next word that is queued carries bit 27 = 1, and the word after it carries 0.
- R10: After reset the queue is empty, `rdy_n` = 1, `tok_out` = 0 and `ser_dat` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_chan | input | 2 | Channel of the offered sample |
| smp_data | input | 24 | Filtered sample value |
| mod_flag | input | 4 | Per-channel modulator flag pulses |
| tbrk_in | input | 1 | Time-break input, rising edge starts countdown |
| tb_delay | input | DLY_W | Countdown length in system clocks |
| ser_clk | input | 1 | Serial clock from the controller |
| tok_in | input | 1 | Token from the previous device |
| rdy_n | output | 1 | Active-low data-ready |
| ser_dat | output | 1 | Serial data |
| tok_out | output | 1 | Token to the next device |

## Verification
The bench builds the port with its defaults, a queue depth of 8 and an 8-bit delay field. This small depth lets it fill the queue exactly, push one word past full and observe the overflow marker on the following word. The 8-bit delay field lets it use both a zero-length countdown and a 40-cycle one, so words on both sides of the time-break expiry are reached. Every channel number and two rounds of distinct sample patterns are swept through full queue loads, with each expected word rebuilt arithmetically from the offered channel, sample and pending flags.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int SAMPLE_W = 24;
  localparam int STAT_W   = 8;
  localparam int WORD_W   = SAMPLE_W + STAT_W;
  localparam int NCH      = 4;
  localparam int CH_W     = 2;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_SHIFT = 2'd1,
    XS_TOKO  = 2'd2,
    XS_PASS  = 2'd3
  } xfer_state_t;

  function automatic logic [STAT_W-1:0] make_status(input logic mflag,
                                                    input logic [CH_W-1:0] ch,
                                                    input logic tb,
                                                    input logic ovf);
    return {mflag, ch, tb, ovf, 3'b000};
  endfunction
endpackage

// File: rtl/sop_fifo.sv
module sop_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_comb begin
    wp_nxt  = wp;
    rp_nxt  = rp;
    cnt_nxt = cnt;
    if (do_push) wp_nxt = (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
    if (do_pop)  rp_nxt = (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
    cnt_nxt = cnt + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_nxt;
      rp  <= rp_nxt;
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/sop_tbtimer.sv
module sop_tbtimer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbrk_in,
  input  logic [DLY_W-1:0] delay,
  output logic             fire
);
  logic             tbrk_q, active, active_nxt, rise;
  logic [DLY_W-1:0] cnt, cnt_nxt;

  assign rise = tbrk_in & ~tbrk_q;
  assign fire = active & (cnt == '0);

  always_comb begin
    active_nxt = active;
    cnt_nxt    = cnt;
    if (rise) begin
      active_nxt = 1'b1;
      cnt_nxt    = delay;
    end else if (active) begin
      if (cnt == '0) active_nxt = 1'b0;
      else           cnt_nxt    = cnt - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbrk_q <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      tbrk_q <= tbrk_in;
      active <= active_nxt;
      cnt    <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sop_stamp.sv
module sop_stamp
  import sop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [CH_W-1:0]     smp_chan,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [NCH-1:0]      mod_flag,
  input  logic                tb_fire,
  input  logic                fifo_full,
  output logic                push_ok,
  output logic [WORD_W-1:0]   push_word
);
  logic [NCH-1:0] mpend, mpend_nxt, tpend, tpend_nxt, hit;
  logic           ovf, ovf_nxt;

  assign push_ok = smp_valid & ~fifo_full;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign hit[c]       = push_ok && (smp_chan == CH_W'(c));
    assign mpend_nxt[c] = (mpend[c] & ~hit[c]) | mod_flag[c];
    assign tpend_nxt[c] = (tpend[c] & ~hit[c]) | tb_fire;
  end

  assign ovf_nxt   = (ovf & ~push_ok) | (smp_valid & fifo_full);
  assign push_word = {make_status(mpend[smp_chan], smp_chan, tpend[smp_chan], ovf),
                      smp_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpend <= '0;
      tpend <= '0;
      ovf   <= 1'b0;
    end else begin
      mpend <= mpend_nxt;
      tpend <= tpend_nxt;
      ovf   <= ovf_nxt;
    end
  end
endmodule

// File: rtl/sop_ser.sv
module sop_ser
  import sop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              tok_in,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] rdata,
  output logic              pop,
  output logic              ser_dat,
  output logic              tok_out,
  output logic              sck_rise
);
  localparam int BW = $clog2(WORD_W);

  logic [2:0]        sck_s, tok_s;
  logic              sck_fall, tok_lvl, tok_rise;
  xfer_state_t       st, st_nxt;
  logic [WORD_W-1:0] sreg, sreg_nxt;
  logic [BW-1:0]     bcnt, bcnt_nxt;

  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign sck_fall = ~sck_s[1] & sck_s[2];
  assign tok_lvl  = tok_s[1];
  assign tok_rise = tok_s[1] & ~tok_s[2];

  always_comb begin
    st_nxt   = st;
    sreg_nxt = sreg;
    bcnt_nxt = bcnt;
    pop      = 1'b0;
    unique case (st)
      XS_IDLE: begin
        if (tok_rise) begin
          if (!fifo_empty) begin
            st_nxt   = XS_SHIFT;
            sreg_nxt = rdata;
            bcnt_nxt = '0;
            pop      = 1'b1;
          end else begin
            st_nxt = XS_PASS;
          end
        end
      end
      XS_SHIFT: begin
        if (sck_fall) begin
          if (bcnt == BW'(WORD_W-1)) begin
            st_nxt = XS_TOKO;
          end else begin
            sreg_nxt = {sreg[WORD_W-2:0], 1'b0};
            bcnt_nxt = bcnt + BW'(1);
          end
        end
      end
      XS_TOKO: if (sck_fall) st_nxt = XS_IDLE;
      XS_PASS: if (!tok_lvl) st_nxt = XS_IDLE;
      default: st_nxt = XS_IDLE;
    endcase
  end

  assign ser_dat = (st == XS_SHIFT) & sreg[WORD_W-1];
  assign tok_out = (st == XS_TOKO) | ((st == XS_PASS) & tok_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      tok_s <= '0;
      st    <= XS_IDLE;
      sreg  <= '0;
      bcnt  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], ser_clk};
      tok_s <= {tok_s[1:0], tok_in};
      st    <= st_nxt;
      sreg  <= sreg_nxt;
      bcnt  <= bcnt_nxt;
    end
  end
endmodule

// File: rtl/sample_token_port.sv
module sample_token_port
  import sop_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DLY_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [CH_W-1:0]     smp_chan,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [NCH-1:0]      mod_flag,
  input  logic                tbrk_in,
  input  logic [DLY_W-1:0]    tb_delay,
  input  logic                ser_clk,
  input  logic                tok_in,
  output logic                rdy_n,
  output logic                ser_dat,
  output logic                tok_out
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              tb_fire, push_ok, pop, fifo_empty, fifo_full, sck_rise;
  logic [WORD_W-1:0] push_word, rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sop_tbtimer #(.DLY_W(DLY_W)) u_tbtimer (
    .clk(clk), .rst_n(rst_int_n), .tbrk_in(tbrk_in), .delay(tb_delay), .fire(tb_fire)
  );

  sop_stamp u_stamp (
    .clk(clk), .rst_n(rst_int_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .mod_flag(mod_flag), .tb_fire(tb_fire),
    .fifo_full(fifo_full), .push_ok(push_ok), .push_word(push_word)
  );

  sop_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .push(push_ok), .pop(pop), .wdata(push_word),
    .rdata(rdata), .empty(fifo_empty), .full(fifo_full)
  );

  sop_ser u_ser (
    .clk(clk), .rst_n(rst_int_n), .ser_clk(ser_clk), .tok_in(tok_in),
    .fifo_empty(fifo_empty), .rdata(rdata), .pop(pop), .ser_dat(ser_dat),
    .tok_out(tok_out), .sck_rise(sck_rise)
  );

  assign rdy_n = fifo_empty;
endmodule

// File: rtl/sop_checker.sv
module sop_checker
  import sop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [CH_W-1:0]   smp_chan,
  input logic              push_ok,
  input logic [WORD_W-1:0] push_word,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              pop,
  input logic              rdy_n,
  input logic              ser_dat,
  input logic              sck_rise
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> (push_word[26:24] == 3'b000)); // R1
  AST_CHAN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> (push_word[30:29] == smp_chan)); // R1
  AST_RDY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !rdy_n); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty); // R4
  AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> $stable(ser_dat)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fifo_full && !pop) |=> fifo_full); // R9
endmodule

bind sample_token_port sop_checker u_sop_checker (
  .clk(clk), .rst_n(rst_int_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
  .push_ok(push_ok), .push_word(push_word), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .pop(pop), .rdy_n(rdy_n), .ser_dat(ser_dat),
  .sck_rise(sck_rise)
);

// File: tb/test_sample_token_port.sv
module test_sample_token_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = 2'd0;
  logic [23:0] smp_data = 24'd0;
  logic [3:0]  mod_flag = 4'd0;
  logic        tbrk_in = 1'b0;
  logic [7:0]  tb_delay = 8'd0;
  logic        ser_clk = 1'b0;
  logic        tok_in = 1'b0;
  logic        rdy_n, ser_dat, tok_out;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sample_token_port i_sample_token_port (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .mod_flag(mod_flag), .tbrk_in(tbrk_in),
    .tb_delay(tb_delay), .ser_clk(ser_clk), .tok_in(tok_in),
    .rdy_n(rdy_n), .ser_dat(ser_dat), .tok_out(tok_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] ch, input logic [23:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input logic m, input logic [1:0] ch,
                                           input logic tb, input logic ovf,
                                           input logic [23:0] d);
    return {m, ch, tb, ovf, 3'b000, d};
  endfunction

  function automatic logic [23:0] pat(input int r, input int i);
    return 24'((r * 8 + i + 1) * 32'h000A3D71) ^ 24'h5A5A5A;
  endfunction

  // Request one word with the token, clock it out and check token and stability.
  task automatic read_word(output logic [31:0] w);
    bit unstable = 1'b0;
    w = '0;
    tok_in = 1'b1;
    wait_n(8);
    tok_in = 1'b0;
    for (int i = 0; i < 32; i++) begin
      w = {w[30:0], ser_dat};
      ser_clk = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (ser_dat !== w[0]) unstable = 1'b1;
      end
      ser_clk = 1'b0;
      wait_n(5);
    end
    check("R6 data stable while serial clock high", {31'd0, unstable}, 32'd0);
    check("R4 token out after 32 bits", {31'd0, tok_out}, 32'd1);
    ser_clk = 1'b1;
    wait_n(5);
    check("R4 token out held through high phase", {31'd0, tok_out}, 32'd1);
    ser_clk = 1'b0;
    wait_n(5);
    check("R4 token out ends after one serial period", {31'd0, tok_out}, 32'd0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    // R10 reset state
    check("R10 rdy_n after reset", {31'd0, rdy_n}, 32'd1);
    check("R10 tok_out after reset", {31'd0, tok_out}, 32'd0);
    check("R10 ser_dat after reset", {31'd0, ser_dat}, 32'd0);

    // R5 pass-through with empty queue
    tok_in = 1'b1;
    wait_n(6);
    check("R5 token passed while empty", {31'd0, tok_out}, 32'd1);
    check("R5 no data while passing", {31'd0, ser_dat}, 32'd0);
    tok_in = 1'b0;
    wait_n(6);
    check("R5 token drop passed", {31'd0, tok_out}, 32'd0);

    // R1 R2 R3 sweep: full queue loads over all channels
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 8; i++) push(2'((i + r) % 4), pat(r, i));
      wait_n(2);
      check("R3 rdy_n low with data", {31'd0, rdy_n}, 32'd0);
      for (int i = 0; i < 8; i++) begin
        read_word(w);
        check("R1 R2 word format and order", w,
              exp_word(1'b0, 2'((i + r) % 4), 1'b0, 1'b0, pat(r, i)));
      end
      check("R3 rdy_n high when drained", {31'd0, rdy_n}, 32'd1);
    end

    // R9 overflow
    for (int i = 0; i < 9; i++) push(2'(i % 4), pat(5, i));
    for (int i = 0; i < 8; i++) begin
      read_word(w);
      check("R9 queued words intact", w, exp_word(1'b0, 2'(i % 4), 1'b0, 1'b0, pat(5, i)));
    end
    check("R9 dropped word absent", {31'd0, rdy_n}, 32'd1);
    push(2'd1, 24'h123456);
    push(2'd2, 24'hABCDEF);
    read_word(w);
    check("R9 overflow marked on next word", w, exp_word(1'b0, 2'd1, 1'b0, 1'b1, 24'h123456));
    read_word(w);
    check("R9 overflow cleared", w, exp_word(1'b0, 2'd2, 1'b0, 1'b0, 24'hABCDEF));

    // R7 modulator flags
    @(negedge clk); mod_flag = 4'b0100;
    @(negedge clk); mod_flag = 4'b0000;
    push(2'd1, 24'h000111);
    push(2'd2, 24'h000222);
    push(2'd2, 24'h000333);
    @(negedge clk); mod_flag = 4'b1001;
    @(negedge clk); mod_flag = 4'b0000;
    push(2'd0, 24'h000444);
    push(2'd3, 24'h000555);
    read_word(w); check("R7 other channel untouched", w, exp_word(1'b0, 2'd1, 1'b0, 1'b0, 24'h000111));
    read_word(w); check("R7 flag on next word", w, exp_word(1'b1, 2'd2, 1'b0, 1'b0, 24'h000222));
    read_word(w); check("R7 flag cleared", w, exp_word(1'b0, 2'd2, 1'b0, 1'b0, 24'h000333));
    read_word(w); check("R7 flag channel 0", w, exp_word(1'b1, 2'd0, 1'b0, 1'b0, 24'h000444));
    read_word(w); check("R7 flag channel 3", w, exp_word(1'b1, 2'd3, 1'b0, 1'b0, 24'h000555));

    // R8 time break with a 40-cycle delay
    tb_delay = 8'd40;
    @(negedge clk); tbrk_in = 1'b1;
    @(negedge clk); tbrk_in = 1'b0;
    for (int c = 0; c < 4; c++) push(2'(c), pat(7, c));
    for (int c = 0; c < 4; c++) begin
      read_word(w);
      check("R8 no marker before expiry", w, exp_word(1'b0, 2'(c), 1'b0, 1'b0, pat(7, c)));
    end
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++) push(2'(3 - c), pat(8 + r, c));
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++) begin
        read_word(w);
        check("R8 marker exactly once per channel", w,
              exp_word(1'b0, 2'(3 - c), (r == 0), 1'b0, pat(8 + r, c)));
      end

    // R8 zero delay
    tb_delay = 8'd0;
    @(negedge clk); tbrk_in = 1'b1;
    @(negedge clk); tbrk_in = 1'b0;
    wait_n(4);
    push(2'd2, 24'hC0FFEE);
    read_word(w);
    check("R8 zero delay marker", w, exp_word(1'b0, 2'd2, 1'b1, 1'b0, 24'hC0FFEE));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule